// File: doc/BRIEF.md
# Tagged Handshake Pipeline Chain

This block is a configurable run of register stages that carries one operation's worth of data through a floating-point datapath. Each operation has three parts: an opaque payload word, a tag that the issuer picks to recognise the result, and a five-bit exception-flag word. The three parts move together through the stages. Both ends use a valid/ready handshake. The arithmetic that would normally sit between the stages is not part of this block, so the payload comes out exactly as it went in.

Each stage holds a single operation. A stage advances whenever it is empty or its successor is taking its contents in the same cycle, so an empty slot further down lets the stages above it move forward. A synchronous flush empties every stage. A busy output shows whether anything is still inside. When the stage count is set to zero, the chain becomes a purely combinational connection: output follows input, and ready follows ready.

Top module: `fp_stage_chain`

## Requirements
- R1: While reset is low and after it is released, with no input accepted, out_valid and busy are 0 and in_ready is 1.
- R2: An operation is accepted on a rising edge where in_valid and in_ready are both 1. With out_ready held at 1, it appears at the output exactly NUM_STAGES cycles later, and a new operation can be accepted on every cycle.
- R3: A stage stalls only when the stage after it is stalled. With out_ready at 0 the chain accepts exactly NUM_STAGES operations before in_ready falls, and raising out_ready makes in_ready 1 again in the same cycle.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data, out_tag and out_flags hold their values on the next cycle, unless flush is asserted.
- R5: Operations leave in the order they entered, with none lost and none repeated. out_data, out_tag and out_flags are bit-identical to the values accepted with that operation.
- R6: A cycle with flush at 1 empties every stage on that edge. Any operation accepted in that same cycle is discarded. On the next cycle out_valid and busy are 0, and nothing from before the flush comes out afterwards.
- R7: busy is 1 exactly when some stage holds an operation. busy is therefore 1 whenever out_valid is 1, and in_ready is 1 whenever busy is 0.
- R8: With NUM_STAGES = 0, the output fields and out_valid equal the corresponding inputs combinationally, in_ready equals out_ready, busy is 0, and flush has no effect.
- R9: Driving rst_n low empties the chain at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty of all stages |
| in_valid | input | 1 | Upstream offers an operation |
| in_ready | output | 1 | Chain can take an operation this edge |
| in_data | input | DATA_W | Payload of the offered operation |
| in_tag | input | TAG_W | Issuer tag of the offered operation |
| in_flags | input | 5 | Exception flags {invalid, div-by-zero, overflow, underflow, inexact} |
| out_valid | output | 1 | Chain offers a finished operation |
| out_ready | input | 1 | Downstream takes the operation this edge |
| out_data | output | DATA_W | Payload leaving the chain |
| out_tag | output | TAG_W | Tag leaving the chain |
| out_flags | output | 5 | Flags leaving the chain |
| busy | output | 1 | Some stage holds an operation |

## Verification
Two things can happen in the same cycle: an operation enters at the top while the bottom is stalled or being drained, and a flush arrives while an input is on offer. The bench drives in_valid and out_ready from independent pseudo-random streams for several thousand cycles, so acceptance, stalls and departures overlap in every combination. Every departing operation is compared with the next expected index, which is worked out from how many operations were accepted. It also raises flush together with in_valid over a partly full chain, and then requires that neither the flushed operations nor the one offered in that cycle ever come out.

// File: rtl/fpchain_pkg.sv
package fpchain_pkg;

  // Exception flag word carried alongside every operation.
  typedef struct packed {
    logic invalid;
    logic div_zero;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;

  localparam int unsigned FLAG_W = $bits(fp_flags_t);

endpackage

// File: rtl/fpchain_stage.sv
module fpchain_stage #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [WORD_W-1:0] up_word,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [WORD_W-1:0] dn_word
);

  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              load_en;

  // Stall only when occupied and the successor refuses.
  assign up_ready = ~vld_q | dn_ready;
  assign load_en  = up_valid & up_ready;

  always_comb begin
    vld_d  = vld_q;
    word_d = word_q;
    if (up_ready) vld_d = up_valid;
    if (load_en)  word_d = up_word;
    if (flush)    vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_en) word_q <= word_d;
    end
  end

  assign dn_valid = vld_q;
  assign dn_word  = word_q;

  // R4: a refused output holds still
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready && !flush) |=> (dn_valid && $stable(dn_word)));

  // R6: flush leaves the stage empty
  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dn_valid);

  // R5: an accepted word is what the stage presents next
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && !flush) |=> (dn_valid && dn_word == $past(up_word)));

endmodule

// File: rtl/fpchain_occupancy.sv
module fpchain_occupancy #(
  parameter int unsigned NUM = 1
) (
  input  logic [NUM-1:0] stage_valid,
  output logic           any_valid
);

  assign any_valid = |stage_valid;

endmodule

// File: rtl/fp_stage_chain.sv
module fp_stage_chain
  import fpchain_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned NUM_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic [FLAG_W-1:0] out_flags,
  output logic              busy
);

  localparam int unsigned WORD_W = DATA_W + TAG_W + FLAG_W;

  logic [WORD_W-1:0] in_word, out_word;

  assign in_word = {in_data, in_tag, in_flags};
  assign {out_data, out_tag, out_flags} = out_word;

  generate
    if (NUM_STAGES == 0) begin : g_comb
      assign out_valid = in_valid;
      assign in_ready  = out_ready;
      assign out_word  = in_word;
      assign busy      = 1'b0;

      // R8: flush leaves the passthrough untouched
      assert_comb_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && in_valid) |-> (out_valid && !busy));
    end else begin : g_pipe
      logic [NUM_STAGES:0]             link_vld;
      logic [NUM_STAGES:0]             link_rdy;
      logic [NUM_STAGES:0][WORD_W-1:0] link_word;

      assign link_vld[0]          = in_valid;
      assign in_ready             = link_rdy[0];
      assign link_word[0]         = in_word;
      assign out_valid            = link_vld[NUM_STAGES];
      assign link_rdy[NUM_STAGES] = out_ready;
      assign out_word             = link_word[NUM_STAGES];

      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        fpchain_stage #(.WORD_W(WORD_W)) u_stage (
          .clk      (clk),
          .rst_n    (rst_n),
          .flush    (flush),
          .up_valid (link_vld[i]),
          .up_ready (link_rdy[i]),
          .up_word  (link_word[i]),
          .dn_valid (link_vld[i+1]),
          .dn_ready (link_rdy[i+1]),
          .dn_word  (link_word[i+1])
        );
      end

      fpchain_occupancy #(.NUM(NUM_STAGES)) u_occ (
        .stage_valid (link_vld[NUM_STAGES:1]),
        .any_valid   (busy)
      );

      // R7: an offered result implies occupancy
      assert_busy_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

      // R7: an empty chain never refuses input
      assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready);

      // R6: after a flush the chain is idle
      assert_flush_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!busy && !out_valid));

      // R3: downstream acceptance frees the top in the same cycle
      assert_ready_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
    end
  endgenerate

endmodule

// File: tb/fp_stage_chain_tb.sv
`timescale 1ns/1ps
module fp_stage_chain_tb;

  localparam int unsigned DW = 16;
  localparam int unsigned TW = 4;
  localparam int unsigned FW = 5;
  localparam int unsigned NS = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic in_valid, in_ready, out_valid, out_ready, busy;
  logic [DW-1:0] in_data, out_data;
  logic [TW-1:0] in_tag, out_tag;
  logic [FW-1:0] in_flags, out_flags;

  logic c_in_valid, c_in_ready, c_out_valid, c_out_ready, c_busy;
  logic [DW-1:0] c_in_data, c_out_data;
  logic [TW-1:0] c_in_tag, c_out_tag;
  logic [FW-1:0] c_in_flags, c_out_flags;

  int errors = 0;
  int checks = 0;
  int wr_k = 0;
  int rd_k = 0;
  logic prev_stall = 1'b0;
  logic [DW+TW+FW-1:0] held_out;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_stage_chain #(.DATA_W(DW), .TAG_W(TW), .NUM_STAGES(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tag(out_tag), .out_flags(out_flags),
    .busy(busy)
  );

  fp_stage_chain #(.DATA_W(DW), .TAG_W(TW), .NUM_STAGES(0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_data(c_in_data), .in_tag(c_in_tag), .in_flags(c_in_flags),
    .out_valid(c_out_valid), .out_ready(c_out_ready),
    .out_data(c_out_data), .out_tag(c_out_tag), .out_flags(c_out_flags),
    .busy(c_busy)
  );

  function automatic logic [DW+TW+FW-1:0] item(input int k);
    logic [31:0] kk;
    logic [31:0] t;
    kk = k;
    t  = kk * 3 + 1;
    item = {kk[15:0] * 16'd37 + 16'd5, t[TW-1:0], kk[FW-1:0] ^ 5'h15};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_item();
    {in_data, in_tag, in_flags} = item(wr_k);
  endtask

  // Called at a falling edge with inputs set; scores the coming rising edge.
  task automatic cyc();
    #1;
    if (prev_stall)
      chk(out_valid && ({out_data, out_tag, out_flags} == held_out),
          "R4 hold under stall", {out_valid, out_data, out_tag, out_flags}, {1'b1, held_out});
    if (in_valid && in_ready) wr_k++;
    if (out_valid && out_ready) begin
      chk({out_data, out_tag, out_flags} == item(rd_k), "R5 order/tag/payload",
          {out_data, out_tag, out_flags}, item(rd_k));
      rd_k++;
    end
    prev_stall = out_valid && !out_ready && !flush;
    held_out   = {out_data, out_tag, out_flags};
    if (flush) rd_k = wr_k;
    @(negedge clk);
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    int acc;
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; in_tag = '0; in_flags = '0;
    c_in_valid = 1'b0; c_out_ready = 1'b0; c_in_data = '0; c_in_tag = '0; c_in_flags = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !busy && in_ready, "R1 during reset", {out_valid, busy, in_ready}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && !busy && in_ready, "R1 after reset", {out_valid, busy, in_ready}, 3'b001);
    @(negedge clk);

    // R2 latency
    out_ready = 1'b1; in_valid = 1'b1; drive_item();
    cyc();
    in_valid = 1'b0;
    lat = 1;
    for (int i = 0; i < NS + 4; i++) begin
      #1;
      if (out_valid) break;
      lat++;
      @(negedge clk);
    end
    chk(lat == NS, "R2 latency", lat, NS);
    cyc();

    // R2 throughput
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; drive_item();
      #0.5;
      chk(in_ready, "R2 back-to-back accept", in_ready, 1);
      cyc();
    end
    in_valid = 1'b0;
    repeat (NS + 2) cyc();
    chk(rd_k == wr_k, "R5 all delivered", rd_k, wr_k);

    // R3 fill under backpressure
    out_ready = 1'b0; acc = 0;
    for (int i = 0; i < NS + 3; i++) begin
      in_valid = 1'b1; drive_item();
      #0.5;
      if (in_ready) acc++;
      cyc();
    end
    chk(acc == NS, "R3 capacity", acc, NS);
    #0.5;
    chk(!in_ready && busy, "R3/R7 full stalls", {in_ready, busy}, 2'b01);
    out_ready = 1'b1;
    #0.5;
    chk(in_ready, "R3 ready follows successor", in_ready, 1);
    in_valid = 1'b0;
    repeat (NS + 2) cyc();
    #0.5;
    chk(!busy && rd_k == wr_k, "R7 idle after drain", {busy, rd_k[7:0]}, {1'b0, wr_k[7:0]});

    // R6 flush with a concurrent offer
    out_ready = 1'b0;
    for (int i = 0; i < 2; i++) begin
      in_valid = 1'b1; drive_item(); cyc();
    end
    in_valid = 1'b1; drive_item(); flush = 1'b1;
    cyc();
    flush = 1'b0; in_valid = 1'b0; prev_stall = 1'b0;
    #1;
    chk(!out_valid && !busy, "R6 empty after flush", {out_valid, busy}, 2'b00);
    out_ready = 1'b1;
    for (int i = 0; i < NS + 2; i++) begin
      #0.5;
      chk(!out_valid, "R6 nothing survives flush", out_valid, 0);
      @(negedge clk);
    end

    // R5 random traffic
    for (int i = 0; i < 4000; i++) begin
      if (!(in_valid && !in_ready)) in_valid = ($urandom % 3) != 0;
      out_ready = ($urandom % 2) == 0;
      drive_item();
      #0.5;
      if (busy == 1'b0) chk(in_ready, "R7 idle means ready", in_ready, 1);
      if (out_valid) chk(busy, "R7 output implies busy", busy, 1);
      cyc();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (NS + 2) cyc();
    chk(rd_k == wr_k, "R5 no loss or duplicate", rd_k, wr_k);

    // R9 asynchronous reset mid-operation
    out_ready = 1'b0; in_valid = 1'b1;
    for (int i = 0; i < 2; i++) begin drive_item(); cyc(); end
    in_valid = 1'b0;
    #1;
    rst_n = 1'b0;
    #0.3;
    chk(!out_valid && !busy, "R9 async clear", {out_valid, busy}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1; prev_stall = 1'b0; rd_k = wr_k;
    @(negedge clk);

    // R8 zero-stage passthrough
    for (int i = 0; i < 16; i++) begin
      c_in_valid  = i[0];
      c_out_ready = i[1];
      flush       = i[2];
      {c_in_data, c_in_tag, c_in_flags} = item(i * 11 + 2);
      #1;
      chk({c_out_data, c_out_tag, c_out_flags} == item(i * 11 + 2), "R8 data passthrough",
          {c_out_data, c_out_tag, c_out_flags}, item(i * 11 + 2));
      chk(c_out_valid == c_in_valid && c_in_ready == c_out_ready && !c_busy, "R8 handshake passthrough",
          {c_out_valid, c_in_ready, c_busy}, {c_in_valid, c_out_ready, 1'b0});
      @(negedge clk);
    end
    flush = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule